// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Registers

This block is the host-visible register set of a two-channel bus-master disk DMA function. It sits in a 16-byte I/O window and gives each channel an 8-byte slice. Each slice holds three things. The command register starts and stops the channel and chooses the transfer direction. The status register combines hardware event flags with drive-capability bits that software owns. The table pointer holds the base address of the channel's descriptor table. The transfer engine reads start, direction and table base from the block. The engine returns completion and error pulses, and the drive returns its interrupt line.

The host performs byte or dword accesses. A byte write always takes its value from data bits 7:0. A dword access ignores the two low address bits and covers the whole aligned word. Reads are combinational and have no side effects. Software clears the status event flags by writing back the value it read. A channel stopped while its active flag is still set gives a one-cycle underrun indication. That case is not treated as an error.

Top module: `busdma_regs`

## Requirements
- R1: After reset every register is zero: every byte offset of the window reads 0, and dmaStart, dmaToMem, dmaTableBase and dmaUnderrun are all 0.
- R2: Channel c occupies offsets 8c..8c+7. The command byte is at offset 0, the status byte at 2, and the table pointer at 4..7, little-endian. Offsets 1 and 3 read 0. A dword read at offset 0 returns {8'h00, status, 8'h00, command}.
- R3: Command bit 0 is start and bit 3 is direction, where 1 means drive to memory. The two bits appear on dmaStart and dmaToMem one cycle after the write. All other command bits read 0.
- R4: The table pointer accepts byte and dword writes. Bits 1:0 always read 0. The full value appears on dmaTableBase[32c+31:32c].
- R5: Status bit 1 (error) and bit 2 (interrupt) clear when a 1 is written to them. Writing 0 to them leaves them unchanged.
- R6: Status bits 5 and 6 are read/write drive-capability bits, and the flag-clearing action does not touch them. Writes to status bits 0, 3, 4 and 7 have no effect.
- R7: Status bit 0 (active) sets when start goes from 0 to 1. It clears on an engDone pulse.
- R8: The interrupt flag sets on a rising edge of drvIrq while start is 1. A level held high does not set it again, and a rising edge while start is 0 does not set it.
- R9: An engError pulse sets the error flag. If the pulse arrives in the same cycle as a clearing write, the pulse wins.
- R10: Clearing start while active is 1 pulses dmaUnderrun for exactly one cycle and clears active. The error flag is not set.
- R11: Each channel's registers, flags and outputs are independent of the other channel's accesses and events.
- R12: A byte write uses data bits 7:0 whatever its byte offset. A dword write ignores address bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 4 | Byte offset in the window |
| hostWr | input | 1 | Write strobe |
| hostDword | input | 1 | 1 = dword access, 0 = byte access |
| hostWrData | input | 32 | Write data |
| hostRdData | output | 32 | Combinational read data |
| engDone | input | 2 | Per-channel transfer-complete pulse |
| engError | input | 2 | Per-channel engine error pulse |
| drvIrq | input | 2 | Per-channel drive interrupt level |
| dmaStart | output | 2 | Per-channel start bit |
| dmaToMem | output | 2 | Per-channel direction (1 = drive to memory) |
| dmaTableBase | output | 64 | Per-channel descriptor-table base |
| dmaUnderrun | output | 2 | Per-channel underrun pulse |

## Verification
On every cycle, the assertions check the following. The interrupt flag rises only after a drive interrupt seen with start set. The error flag rises only after an engine error pulse. A status write with a 0 in the error position never drops a set error flag. Active rises only together with start. Every underrun pulse follows an active channel that has just stopped. Only the bench's scenarios can show the rest: the exact byte and lane mapping of the window, the full 256-value sweeps of command and status writes, pointer masking, channel independence, and priority when a set and a clear coincide.

// File: rtl/busdma_pkg.sv
package busdma_pkg;
  typedef struct packed {
    logic       cmdWe;
    logic       statWe;
    logic [3:0] tblBe;
  } chStrobe_t;

  localparam int CMD_START = 0;
  localparam int CMD_TOMEM = 3;
  localparam int ST_ACT    = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_INT    = 2;
  localparam int ST_CAP_LO = 5;
  localparam int ST_CAP_HI = 6;
  localparam int STAT_LANE = 2;
endpackage

// File: rtl/busdma_ctrl.sv
module busdma_ctrl
  import busdma_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CH_BITS = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW = CH_BITS + 3
) (
  input  logic [AW-1:0]          hostAddr,
  input  logic                   hostWr,
  input  logic                   hostDword,
  input  logic [31:0]            hostWrData,
  input  logic [NCH-1:0][31:0]   chLow,
  input  logic [NCH-1:0][31:0]   chHigh,
  output chStrobe_t [NCH-1:0]    chStb,
  output logic [31:0]            laneData,
  output logic [31:0]            hostRdData
);
  logic [CH_BITS-1:0] chSel;
  logic               wordSel;
  logic [1:0]         byteSel;
  logic [31:0]        selWord;

  assign chSel   = hostAddr[AW-1:3];
  assign wordSel = hostAddr[2];
  assign byteSel = hostAddr[1:0];

  // byte writes place data[7:0] on every lane
  assign laneData = hostDword ? hostWrData : {4{hostWrData[7:0]}};

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    logic hit;
    assign hit = hostWr && (chSel == CH_BITS'(c));
    assign chStb[c].cmdWe  = hit && !wordSel && (hostDword || byteSel == 2'd0);
    assign chStb[c].statWe = hit && !wordSel && (hostDword || byteSel == 2'd2);
    for (genvar k = 0; k < 4; k++) begin : g_be
      assign chStb[c].tblBe[k] = hit && wordSel && (hostDword || byteSel == 2'(k));
    end
  end

  always_comb begin
    selWord = '0;
    for (int c = 0; c < NCH; c++) begin
      if (chSel == CH_BITS'(c)) selWord = wordSel ? chHigh[c] : chLow[c];
    end
    if (hostDword) hostRdData = selWord;
    else           hostRdData = {24'h0, selWord[8*byteSel +: 8]};
  end
endmodule

// File: rtl/busdma_chan.sv
module busdma_chan
  import busdma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  chStrobe_t   stb,
  input  logic [31:0] laneData,
  input  logic        engDone,
  input  logic        engError,
  input  logic        drvIrq,
  output logic [7:0]  cmdByte,
  output logic [7:0]  statByte,
  output logic [31:0] tblPtr,
  output logic        underrun
);
  logic       startQ, toMemQ, actQ, errQ, intQ, irqPrevQ, underrunQ;
  logic [1:0] capQ;
  logic [31:0] tblQ;
  logic [7:0] cmdLane, statLane;
  logic       startRise, stopNow, irqEdge;

  assign cmdLane   = laneData[7:0];
  assign statLane  = laneData[8*STAT_LANE +: 8];
  assign startRise = stb.cmdWe && cmdLane[CMD_START] && !startQ;
  assign stopNow   = stb.cmdWe && !cmdLane[CMD_START] && startQ;
  assign irqEdge   = drvIrq && !irqPrevQ && startQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= 1'b0; toMemQ <= 1'b0; actQ <= 1'b0; errQ <= 1'b0;
      intQ <= 1'b0; irqPrevQ <= 1'b0; underrunQ <= 1'b0;
      capQ <= '0; tblQ <= '0;
    end else begin
      irqPrevQ  <= drvIrq;
      underrunQ <= stopNow && actQ;
      if (stb.cmdWe) begin
        startQ <= cmdLane[CMD_START];
        toMemQ <= cmdLane[CMD_TOMEM];
      end
      if (startRise)               actQ <= 1'b1;
      else if (engDone || stopNow) actQ <= 1'b0;
      if (engError)                                errQ <= 1'b1;
      else if (stb.statWe && statLane[ST_ERR])     errQ <= 1'b0;
      if (irqEdge)                                 intQ <= 1'b1;
      else if (stb.statWe && statLane[ST_INT])     intQ <= 1'b0;
      if (stb.statWe) capQ <= statLane[ST_CAP_HI:ST_CAP_LO];
      for (int k = 0; k < 4; k++) begin
        if (stb.tblBe[k])
          tblQ[8*k +: 8] <= laneData[8*k +: 8] & ((k == 0) ? 8'hFC : 8'hFF);
      end
    end
  end

  assign cmdByte  = {4'h0, toMemQ, 2'b00, startQ};
  assign statByte = {1'b0, capQ, 2'b00, intQ, errQ, actQ};
  assign tblPtr   = tblQ;
  assign underrun = underrunQ;

  AST_INT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intQ) |-> ($past(drvIrq) && $past(startQ))); // R8
  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errQ) |-> $past(engError)); // R9
  AST_ZERO_KEEPS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.statWe && !statLane[ST_ERR] && errQ) |=> errQ); // R5
  AST_ACT_WITH_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(actQ) |-> startQ); // R7
  AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    underrunQ |-> ($past(actQ) && !startQ && !actQ)); // R10
  AST_UNDERRUN_NOT_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (underrunQ && !$past(engError)) |-> !$rose(errQ)); // R10
endmodule

// File: rtl/busdma_datapath.sv
module busdma_datapath
  import busdma_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  chStrobe_t [NCH-1:0]  chStb,
  input  logic [31:0]          laneData,
  input  logic [NCH-1:0]       engDone,
  input  logic [NCH-1:0]       engError,
  input  logic [NCH-1:0]       drvIrq,
  output logic [NCH-1:0][31:0] chLow,
  output logic [NCH-1:0][31:0] chHigh,
  output logic [NCH-1:0]       dmaStart,
  output logic [NCH-1:0]       dmaToMem,
  output logic [NCH*32-1:0]    dmaTableBase,
  output logic [NCH-1:0]       dmaUnderrun
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [7:0]  cmdByte, statByte;
    logic [31:0] tblPtr;
    busdma_chan u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .stb      (chStb[c]),
      .laneData (laneData),
      .engDone  (engDone[c]),
      .engError (engError[c]),
      .drvIrq   (drvIrq[c]),
      .cmdByte  (cmdByte),
      .statByte (statByte),
      .tblPtr   (tblPtr),
      .underrun (dmaUnderrun[c])
    );
    assign chLow[c]  = {8'h00, statByte, 8'h00, cmdByte};
    assign chHigh[c] = tblPtr;
    assign dmaStart[c] = cmdByte[CMD_START];
    assign dmaToMem[c] = cmdByte[CMD_TOMEM];
    assign dmaTableBase[32*c +: 32] = tblPtr;
  end
endmodule

// File: rtl/busdma_regs.sv
module busdma_regs
  import busdma_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CH_BITS = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW = CH_BITS + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     hostAddr,
  input  logic              hostWr,
  input  logic              hostDword,
  input  logic [31:0]       hostWrData,
  output logic [31:0]       hostRdData,
  input  logic [NCH-1:0]    engDone,
  input  logic [NCH-1:0]    engError,
  input  logic [NCH-1:0]    drvIrq,
  output logic [NCH-1:0]    dmaStart,
  output logic [NCH-1:0]    dmaToMem,
  output logic [NCH*32-1:0] dmaTableBase,
  output logic [NCH-1:0]    dmaUnderrun
);
  chStrobe_t [NCH-1:0]  chStb;
  logic [31:0]          laneData;
  logic [NCH-1:0][31:0] chLow, chHigh;

  busdma_ctrl #(.NCH(NCH)) u_ctrl (
    .hostAddr   (hostAddr),
    .hostWr     (hostWr),
    .hostDword  (hostDword),
    .hostWrData (hostWrData),
    .chLow      (chLow),
    .chHigh     (chHigh),
    .chStb      (chStb),
    .laneData   (laneData),
    .hostRdData (hostRdData)
  );

  busdma_datapath #(.NCH(NCH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .chStb        (chStb),
    .laneData     (laneData),
    .engDone      (engDone),
    .engError     (engError),
    .drvIrq       (drvIrq),
    .chLow        (chLow),
    .chHigh       (chHigh),
    .dmaStart     (dmaStart),
    .dmaToMem     (dmaToMem),
    .dmaTableBase (dmaTableBase),
    .dmaUnderrun  (dmaUnderrun)
  );
endmodule

// File: tb/busdma_regs_tb.sv
module busdma_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic        hostWr = 1'b0, hostDword = 1'b0;
  logic [31:0] hostWrData = '0, hostRdData;
  logic [1:0]  engDone = '0, engError = '0, drvIrq = '0;
  logic [1:0]  dmaStart, dmaToMem, dmaUnderrun;
  logic [63:0] dmaTableBase;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busdma_regs u_dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostDword(hostDword), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .engDone(engDone), .engError(engError), .drvIrq(drvIrq),
    .dmaStart(dmaStart), .dmaToMem(dmaToMem), .dmaTableBase(dmaTableBase),
    .dmaUnderrun(dmaUnderrun)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d, input logic dw);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostDword = dw; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0; hostDword = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, input logic dw, output logic [31:0] d);
    hostAddr = a; hostDword = dw;
    #1;
    d = hostRdData;
    hostDword = 1'b0;
  endtask

  task automatic pulseDone(input int c);
    @(negedge clk); engDone[c] = 1'b1;
    @(negedge clk); engDone[c] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired before the sequence finished (all requirements)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] ch1Stat;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state across the whole window
    for (int a = 0; a < 16; a++) begin
      busRead(4'(a), 1'b0, rd);
      chk("R1", $sformatf("reset byte %0d", a), rd, 0);
    end
    chk("R1", "reset outputs", {dmaStart, dmaToMem, dmaUnderrun}, 0);
    chk("R1", "reset table base lo", dmaTableBase[31:0], 0);
    chk("R1", "reset table base hi", dmaTableBase[63:32], 0);

    // R3: exhaustive command byte sweep on channel 0
    for (int v = 0; v < 256; v++) begin
      busWrite(4'd0, 32'(v), 1'b0);
      busRead(4'd0, 1'b0, rd);
      chk("R3", $sformatf("cmd readback v=%0d", v), rd, 32'(v & 8'h09));
      chk("R3", $sformatf("start/dir pins v=%0d", v), {dmaStart[0], dmaToMem[0]},
          {v[0], v[3]});
    end
    busWrite(4'd0, 32'h0, 1'b0);
    pulseDone(0);

    // R4 R12: table pointer, masking, byte lanes, dword misalignment
    busWrite(4'd4, 32'hDEADBEEF, 1'b1);
    busRead(4'd4, 1'b1, rd);
    chk("R4", "dword table write", rd, 32'hDEADBEEC);
    chk("R4", "table base pin ch0", dmaTableBase[31:0], 32'hDEADBEEC);
    busWrite(4'd7, 32'hFFFFFF12, 1'b0);
    busWrite(4'd4, 32'h00000057, 1'b0);
    busRead(4'd4, 1'b1, rd);
    chk("R12", "byte writes take data[7:0]", rd, 32'h12ADBE54);
    busWrite(4'd13, 32'h01234567, 1'b1);
    busRead(4'd12, 1'b1, rd);
    chk("R12", "dword write ignores addr[1:0]", rd, 32'h01234564);
    chk("R11", "ch0 table untouched by ch1", dmaTableBase[31:0], 32'h12ADBE54);
    for (int k = 0; k < 4; k++) begin
      busRead(4'(12 + k), 1'b0, rd);
      chk("R4", $sformatf("ch1 table byte %0d", k), rd,
          32'((32'h01234564 >> (8*k)) & 32'hFF));
    end

    // R7 R10: active flag and underrun on channel 1
    busWrite(4'd8, 32'h01, 1'b0);
    busRead(4'd10, 1'b0, rd);
    chk("R7", "active set on start", rd, 32'h01);
    pulseDone(1);
    busRead(4'd10, 1'b0, rd);
    chk("R7", "active cleared by done", rd, 32'h00);
    busWrite(4'd8, 32'h00, 1'b0);
    chk("R10", "no underrun when idle stop", dmaUnderrun, 2'b00);
    busWrite(4'd8, 32'h01, 1'b0);
    busWrite(4'd8, 32'h00, 1'b0);
    chk("R10", "underrun pulse", dmaUnderrun, 2'b10);
    busRead(4'd10, 1'b0, rd);
    chk("R10", "active cleared, no error", rd, 32'h00);
    @(negedge clk);
    chk("R10", "underrun lasts one cycle", dmaUnderrun, 2'b00);

    // R8: interrupt edge detection on channel 0
    busWrite(4'd0, 32'h01, 1'b0);
    pulseDone(0);
    drvIrq[0] = 1'b1;
    @(negedge clk);
    busRead(4'd2, 1'b0, rd);
    chk("R8", "edge with start sets int", rd, 32'h04);
    busWrite(4'd2, 32'h04, 1'b0);
    repeat (2) @(negedge clk);
    busRead(4'd2, 1'b0, rd);
    chk("R8", "held level does not re-set", rd, 32'h00);
    drvIrq[0] = 1'b0;
    busWrite(4'd0, 32'h00, 1'b0);
    @(negedge clk); drvIrq[0] = 1'b1;
    @(negedge clk);
    busWrite(4'd0, 32'h01, 1'b0);
    repeat (2) @(negedge clk);
    busRead(4'd2, 1'b0, rd);
    chk("R8", "edge while stopped ignored", rd, 32'h01);
    drvIrq[0] = 1'b0;
    pulseDone(0);

    // R9: error pulse and set-beats-clear
    @(negedge clk); engError[0] = 1'b1;
    @(negedge clk); engError[0] = 1'b0;
    busRead(4'd2, 1'b0, rd);
    chk("R9", "error pulse sets flag", rd, 32'h02);
    @(negedge clk);
    hostAddr = 4'd2; hostWrData = 32'h02; hostWr = 1'b1; engError[0] = 1'b1;
    @(negedge clk);
    hostWr = 1'b0; engError[0] = 1'b0;
    busRead(4'd2, 1'b0, rd);
    chk("R9", "set wins over clear", rd, 32'h02);
    busWrite(4'd2, 32'h02, 1'b0);
    busRead(4'd2, 1'b0, rd);
    chk("R5", "write one clears error", rd, 32'h00);

    // R5 R6 R11: exhaustive status write sweep on channel 0
    busWrite(4'd10, 32'h40, 1'b0);
    busRead(4'd10, 1'b0, ch1Stat);
    for (int v = 0; v < 256; v++) begin
      logic [7:0] vb;
      vb = 8'(v);
      @(negedge clk); engError[0] = 1'b1; drvIrq[0] = 1'b1;
      @(negedge clk); engError[0] = 1'b0; drvIrq[0] = 1'b0;
      busWrite(4'd2, 32'(v), 1'b0);
      busRead(4'd2, 1'b0, rd);
      chk("R5 R6", $sformatf("status after write v=%0d", v), rd,
          {24'h0, 1'b0, vb[6], vb[5], 2'b00, ~vb[2], ~vb[1], 1'b0});
    end
    busRead(4'd10, 1'b0, rd);
    chk("R11", "ch1 status untouched by ch0 sweep", rd, ch1Stat);
    chk("R11", "ch1 start stays low", dmaStart[1], 1'b0);

    // R2: dword view of command and status, unmapped bytes
    busWrite(4'd0, 32'h00600008, 1'b1);
    busRead(4'd0, 1'b1, rd);
    chk("R2", "dword read at offset 0", rd, 32'h00600008);
    busRead(4'd1, 1'b0, rd);
    chk("R2", "offset 1 reads zero", rd, 0);
    busRead(4'd3, 1'b0, rd);
    chk("R2", "offset 3 reads zero", rd, 0);
    busRead(4'd9, 1'b0, rd);
    chk("R2", "offset 9 reads zero", rd, 0);
    chk("R3", "direction pin ch0", dmaToMem, 2'b01);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule